// File: doc/BRIEF.md
# Power-On Reset Release Sequencer

This block turns a digital power-good flag from an external supply comparator into an ordered release of the chip from reset. While the supply is low it holds the system reset, stops the main and internal oscillators, stops both watchdogs and takes control of the port pads. One pad is driven low and every other pad is left floating. The always-on subclock oscillator is never touched.

Once power is good and the flag has passed a two-stage synchronizer, the system reset lifts. In that same cycle the oscillators and both watchdogs are enabled. The second watchdog receives a tick every eighth cycle of the sequencing clock. That clock is taken as the internal oscillator clock. A stabilization counter then runs for a selectable number of cycles. Only after it expires are the peripheral, system and CPU clocks enabled and the CPU reset released.

The stabilization length comes from a 3-bit selection. It is captured from a strap input while reset is held and frozen once reset lifts. The clock divider default presented to the clock generator is always divide-by-8. If power drops at any moment, the whole sequence returns to its reset state and the counter restarts from zero.

Top module: `por_seq_top`

## Requirements
- R1: `sys_rst_n` goes low at once, without waiting for a clock, whenever `pwr_good` is low. After `pwr_good` rises, `sys_rst_n` rises on the second rising edge of `clk`.
- R2: `main_osc_en` and `int_osc_en` are low while `sys_rst_n` is low, and both are high in the same cycle that `sys_rst_n` is high.
- R3: `sub_osc_en` is high at all times, including during reset.
- R4: `periph_clk_en`, `sys_clk_en`, `cpu_clk_en` and `cpu_rst_n` stay low until `stab_done` is high. `stab_done` rises exactly 2^(STAB_BASE_LOG2 + 2*sel) rising edges after `sys_rst_n` rises. STAB_BASE_LOG2 defaults to 10, and sel is the 3-bit stabilization selection.
- R5: The selection is taken from `stab_sel_strap` only while `sys_rst_n` is low. A change of the strap after release has no effect on the stabilization length.
- R6: `clk_div_sel` reads 3 both during reset and after release. The code is log2 of the division ratio, so 3 means divide-by-8.
- R7: `wdt1_clk_en` is low during reset and high in the same cycle that `sys_rst_n` is high.
- R8: `wdt2_run` follows `sys_rst_n` without waiting for stabilization. `wdt2_tick` is low in reset and, while running, is high for exactly one cycle in every 8.
- R9: During reset `io_force` is 1, `io_oe` has only bit 0 set (pad 0 driven), and `io_out` is all zero. After release `io_force` and `io_oe` are 0.
- R10: If `pwr_good` falls during the stabilization count, every output returns at once to its reset state. The next release then waits the full stabilization length again, counted from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencing clock (internal oscillator clock) |
| pwr_good | input | 1 | Asynchronous supply-good flag, 1 = supply at or above threshold |
| stab_sel_strap | input | 3 | Stabilization selection default, captured during reset |
| sys_rst_n | output | 1 | System reset, active low |
| main_osc_en | output | 1 | Main oscillator enable |
| int_osc_en | output | 1 | Internal oscillator enable |
| sub_osc_en | output | 1 | Subclock oscillator enable, always 1 |
| wdt1_clk_en | output | 1 | First watchdog clock enable |
| wdt2_run | output | 1 | Second watchdog run enable |
| wdt2_tick | output | 1 | Second watchdog count strobe, one cycle in 8 |
| periph_clk_en | output | 1 | Peripheral clock enable |
| sys_clk_en | output | 1 | Internal system clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_rst_n | output | 1 | CPU reset, active low |
| clk_div_sel | output | 3 | System/CPU clock divider default, log2 of ratio |
| io_force | output | 1 | 1 = pads are under reset control |
| io_oe | output | 8 | Pad output enables during reset |
| io_out | output | 8 | Pad output values during reset |
| stab_done | output | 1 | Stabilization period complete |

## Verification
The assertions assume that `clk` keeps running while `pwr_good` is low. They also assume that `pwr_good`, although asynchronous, stays stable for at least two clock edges after it rises before any fall, and that the strap is a static level during reset. The stimulus changes `pwr_good` and the strap only on falling clock edges. It holds power high for more than the synchronizer depth before dropping it, and it changes the strap after release only to show that the change has no effect. The stabilization base is reduced in the bench so that the largest selection remains a short run.

// File: rtl/por_pkg.sv
package por_pkg;
   // log2 of the division ratio presented to the clock generator
   typedef logic [2:0] div_code_t;
   localparam div_code_t DIV_BY_8 = 3'd3;
   localparam int SEL_W = 3;
   typedef logic [SEL_W-1:0] stab_sel_t;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n_in,
   output logic rst_n_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("por_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] q;

   always_ff @(posedge clk or negedge arst_n_in) begin
      if (!arst_n_in) q <= '0;
      else            q <= {q[STAGES-2:0], 1'b1};
   end

   assign rst_n_out = q[STAGES-1];

   // R1
   rise_order_chk: assert property (@(posedge clk) disable iff (!arst_n_in)
      $rose(q[STAGES-1]) |-> $past(q[STAGES-2]));
endmodule

// File: rtl/por_stab_timer.sv
module por_stab_timer
   import por_pkg::*;
#(
   parameter int BASE_LOG2 = 10,
   parameter int STEP_LOG2 = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  stab_sel_t sel_strap,
   output logic      done
);
   localparam int MAX_SEL = (1 << SEL_W) - 1;
   localparam int CNT_W   = BASE_LOG2 + STEP_LOG2 * MAX_SEL + 1;

   generate
      if (BASE_LOG2 < 1 || STEP_LOG2 < 0 || CNT_W > 31) begin : g_bad
         $error("por_stab_timer: unsupported stabilization range");
      end
   endgenerate

   stab_sel_t        sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tc_m1;
   int               shamt;

   // Selection register: follows the strap only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= sel_strap;
   end

   always_comb begin
      shamt = BASE_LOG2 + STEP_LOG2 * int'(sel_q);
      tc_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else if (!done) begin
         if (cnt_q == tc_m1) done  <= 1'b1;
         else                cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= tc_m1);
   // R4
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);
   // R5
   sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(sel_q));
endmodule

// File: rtl/por_tick_div.sv
module por_tick_div #(
   parameter int DIV_LOG2 = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV_LOG2 < 0) begin : g_bad
         $error("por_tick_div: DIV_LOG2 must not be negative");
      end else if (DIV_LOG2 == 0) begin : g_pass
         assign tick = rst_n;
      end else begin : g_cnt
         logic [DIV_LOG2-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_q <= '0;
            else        div_q <= div_q + 1'b1;
         end
         assign tick = rst_n && (div_q == {DIV_LOG2{1'b1}});

         // R8
         tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/por_io_default.sv
module por_io_default #(
   parameter int NPINS   = 8,
   parameter int LOW_PIN = 0
) (
   input  logic             rst_n,
   output logic             force_o,
   output logic [NPINS-1:0] oe_o,
   output logic [NPINS-1:0] out_o
);
   generate
      if (LOW_PIN < 0 || LOW_PIN >= NPINS) begin : g_bad
         $error("por_io_default: LOW_PIN out of range");
      end
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         if (i == LOW_PIN) begin : g_drv
            assign oe_o[i] = !rst_n;
         end else begin : g_hiz
            assign oe_o[i] = 1'b0;
         end
         assign out_o[i] = 1'b0;
      end
   endgenerate

   assign force_o = !rst_n;
endmodule

// File: rtl/por_seq_top.sv
module por_seq_top
   import por_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int STAB_BASE_LOG2 = 10,
   parameter int STAB_STEP_LOG2 = 2,
   parameter int WDT2_DIV_LOG2  = 3,
   parameter int NPINS          = 8,
   parameter int LOW_PIN        = 0
) (
   input  logic             clk,
   input  logic             pwr_good,
   input  logic [2:0]       stab_sel_strap,
   output logic             sys_rst_n,
   output logic             main_osc_en,
   output logic             int_osc_en,
   output logic             sub_osc_en,
   output logic             wdt1_clk_en,
   output logic             wdt2_run,
   output logic             wdt2_tick,
   output logic             periph_clk_en,
   output logic             sys_clk_en,
   output logic             cpu_clk_en,
   output logic             cpu_rst_n,
   output logic [2:0]       clk_div_sel,
   output logic             io_force,
   output logic [NPINS-1:0] io_oe,
   output logic [NPINS-1:0] io_out,
   output logic             stab_done
);
   logic rst_n_s;

   por_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .arst_n_in (pwr_good),
      .rst_n_out (rst_n_s)
   );

   por_stab_timer #(
      .BASE_LOG2 (STAB_BASE_LOG2),
      .STEP_LOG2 (STAB_STEP_LOG2)
   ) u_stab (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .sel_strap (stab_sel_strap),
      .done      (stab_done)
   );

   por_tick_div #(.DIV_LOG2(WDT2_DIV_LOG2)) u_wdt2 (
      .clk   (clk),
      .rst_n (rst_n_s),
      .tick  (wdt2_tick)
   );

   por_io_default #(.NPINS(NPINS), .LOW_PIN(LOW_PIN)) u_io (
      .rst_n   (rst_n_s),
      .force_o (io_force),
      .oe_o    (io_oe),
      .out_o   (io_out)
   );

   // Domains that start as soon as reset lifts
   assign sys_rst_n   = rst_n_s;
   assign main_osc_en = rst_n_s;
   assign int_osc_en  = rst_n_s;
   assign wdt1_clk_en = rst_n_s;
   assign wdt2_run    = rst_n_s;
   assign sub_osc_en  = 1'b1;

   // Domains that wait for the stabilization count
   assign periph_clk_en = stab_done;
   assign sys_clk_en    = stab_done;
   assign cpu_clk_en    = stab_done;
   assign cpu_rst_n     = stab_done;

   assign clk_div_sel = DIV_BY_8;

   // R4
   cpu_after_rst_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      cpu_rst_n |-> sys_rst_n);
   // R8
   wdt_idle_rst_chk: assert property (@(posedge clk) disable iff (!pwr_good)
      !sys_rst_n |-> !wdt2_tick);
endmodule

// File: tb/sim_por_seq_top.sv
module sim_por_seq_top;
   localparam int BASE = 2;

   logic       clk = 1'b0;
   logic       pwr_good = 1'b0;
   logic [2:0] strap = 3'd0;
   logic sys_rst_n, main_osc_en, int_osc_en, sub_osc_en, wdt1_clk_en;
   logic wdt2_run, wdt2_tick, periph_clk_en, sys_clk_en, cpu_clk_en;
   logic cpu_rst_n, io_force, stab_done;
   logic [2:0] clk_div_sel;
   logic [7:0] io_oe, io_out;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   por_seq_top #(.STAB_BASE_LOG2(BASE)) u0 (
      .clk(clk), .pwr_good(pwr_good), .stab_sel_strap(strap),
      .sys_rst_n(sys_rst_n), .main_osc_en(main_osc_en), .int_osc_en(int_osc_en),
      .sub_osc_en(sub_osc_en), .wdt1_clk_en(wdt1_clk_en), .wdt2_run(wdt2_run),
      .wdt2_tick(wdt2_tick), .periph_clk_en(periph_clk_en), .sys_clk_en(sys_clk_en),
      .cpu_clk_en(cpu_clk_en), .cpu_rst_n(cpu_rst_n), .clk_div_sel(clk_div_sel),
      .io_force(io_force), .io_oe(io_oe), .io_out(io_out), .stab_done(stab_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int tc(input int sel);
      return 1 << (BASE + 2 * sel);
   endfunction

   // Raise power with a strap value, optionally change the strap after release,
   // and measure the edges to release and to stabilization.
   task automatic power_up(input int sel, input int late_sel,
                           output int rel_edges, output int stab_edges,
                           output int early_en);
      @(negedge clk);
      strap = 3'(sel);
      pwr_good = 1'b1;
      rel_edges = 0;
      early_en = 0;
      do begin
         @(posedge clk); #1;
         rel_edges++;
         if (!sys_rst_n && (main_osc_en || int_osc_en || wdt1_clk_en || wdt2_run))
            early_en++;
      end while (!sys_rst_n && rel_edges < 10);
      @(negedge clk);
      strap = 3'(late_sel);
      stab_edges = 0;
      while (!stab_done && stab_edges < 200000) begin
         if (cpu_rst_n || cpu_clk_en || sys_clk_en || periph_clk_en) early_en++;
         @(posedge clk); #1;
         stab_edges++;
      end
   endtask

   task automatic power_down();
      @(negedge clk);
      pwr_good = 1'b0;
      #1;
   endtask

   task automatic t_reset_state();
      int ticks = 0;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (wdt2_tick) ticks++;
      end
      chk(sys_rst_n == 1'b0, "R1", "sys_rst_n in reset", sys_rst_n, 0);
      chk(main_osc_en == 0 && int_osc_en == 0, "R2", "osc enables in reset",
          {main_osc_en, int_osc_en}, 0);
      chk(sub_osc_en == 1'b1, "R3", "sub_osc_en in reset", sub_osc_en, 1);
      chk(cpu_rst_n == 0 && cpu_clk_en == 0 && sys_clk_en == 0 && periph_clk_en == 0,
          "R4", "late enables in reset",
          {cpu_rst_n, cpu_clk_en, sys_clk_en, periph_clk_en}, 0);
      chk(clk_div_sel == 3'd3, "R6", "divider default in reset", clk_div_sel, 3);
      chk(wdt1_clk_en == 1'b0, "R7", "wdt1 clock in reset", wdt1_clk_en, 0);
      chk(wdt2_run == 1'b0 && ticks == 0, "R8", "wdt2 ticks in reset", ticks, 0);
      chk(io_force == 1'b1, "R9", "io_force in reset", io_force, 1);
      chk(io_oe == 8'h01, "R9", "io_oe in reset", io_oe, 1);
      chk(io_out == 8'h00, "R9", "io_out in reset", io_out, 0);
   endtask

   task automatic t_sequence(input int sel);
      int r, s, e;
      power_up(sel, sel, r, s, e);
      chk(r == 2, "R1", "edges to release", r, 2);
      chk(e == 0, "R2", "enables before their time", e, 0);
      chk(s == tc(sel), "R4", $sformatf("stab edges sel %0d", sel), s, tc(sel));
      @(negedge clk);
      chk(main_osc_en && int_osc_en, "R2", "osc enables after release",
          {main_osc_en, int_osc_en}, 3);
      chk(wdt1_clk_en && wdt2_run, "R7", "watchdog enables after release",
          {wdt1_clk_en, wdt2_run}, 3);
      chk(cpu_rst_n && cpu_clk_en && sys_clk_en && periph_clk_en, "R4",
          "late enables after stab", {cpu_rst_n, cpu_clk_en, sys_clk_en, periph_clk_en}, 15);
      chk(sub_osc_en == 1'b1, "R3", "sub_osc_en running", sub_osc_en, 1);
      chk(clk_div_sel == 3'd3, "R6", "divider default running", clk_div_sel, 3);
      chk(io_force == 0 && io_oe == 0, "R9", "pads released", {io_force, io_oe}, 0);
      power_down();
   endtask

   task automatic t_strap_late();
      int r, s, e;
      power_up(1, 7, r, s, e);
      chk(s == tc(1), "R5", "strap change after release ignored", s, tc(1));
      power_down();
   endtask

   task automatic t_wdt2();
      int r, s, e;
      int ticks = 0;
      int first = -1;
      power_up(0, 0, r, s, e);
      power_down();
      @(negedge clk);
      pwr_good = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      for (int i = 0; i < 64; i++) begin
         if (wdt2_tick) begin
            ticks++;
            if (first < 0) first = i;
         end
         @(posedge clk); #1;
      end
      chk(ticks == 8, "R8", "wdt2 ticks in 64 cycles", ticks, 8);
      chk(first == 7, "R8", "first wdt2 tick offset", first, 7);
      power_down();
   endtask

   task automatic t_brownout();
      int r, s, e;
      @(negedge clk);
      strap = 3'd3;
      pwr_good = 1'b1;
      repeat (100) @(posedge clk);
      power_down();
      chk(sys_rst_n == 0 && main_osc_en == 0 && wdt2_run == 0, "R10",
          "immediate reset on drop", {sys_rst_n, main_osc_en, wdt2_run}, 0);
      chk(io_oe == 8'h01 && io_force == 1, "R10", "pads on drop", io_oe, 1);
      repeat (3) @(negedge clk);
      power_up(3, 3, r, s, e);
      chk(s == tc(3), "R10", "full count after drop", s, tc(3));
      chk(r == 2, "R1", "release after drop", r, 2);
      power_down();
   endtask

   initial begin
      #(4 * 190000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset_state();
      t_sequence(0);
      t_sequence(1);
      t_sequence(3);
      t_sequence(7);
      t_strap_late();
      t_wdt2();
      t_brownout();
      t_reset_state();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule